// File: doc/BRIEF.md
# Tile Background Layer Renderer

The block draws up to four tile-based background layers into a frame-buffer write stream of 16-bit pixels. On a start pulse it latches a 3-bit display mode, which fixes how many layers are drawn, in which order (back to front) and at which colour depth (2, 4 or 8 bits per pixel). For every layer it walks a grid of 8x8-pixel tiles. For each tile it reads a two-byte map entry from byte-addressed video RAM. For each tile row it then fetches the bitplane bytes, forms the colour index of each pixel, reads a two-byte colour from palette RAM and offers the pixel on a valid/ready write port.

Both RAMs are read through synchronous ports with one cycle of latency. Pixels of a later layer are emitted after those of an earlier one, so a frame buffer that simply applies the writes in order ends up with the later layer on top. When the last layer is done, a one-cycle frame-done pulse ends the frame. Grid size and address widths are parameters; the defaults give a 32x28-tile grid, a 256-pixel row and 64 KiB of video RAM.

Top module: `tile_bg_render`

## Requirements
- R1: Out of reset and while idle, `pix_valid_o` and `frame_done_o` stay low.
- R2: The mode is latched at start. It fixes the layers (back to front) and their bits per pixel: mode 0 draws layers 3,2,1,0 at 2 bpp. Mode 1 draws layer 2 at 2 bpp, then layers 1,0 at 4 bpp. Mode 2 draws layers 1,0 at 4 bpp. Mode 3 draws layer 1 at 4 bpp, then layer 0 at 8 bpp. Mode 5 draws layer 1 at 2 bpp, then layer 0 at 4 bpp. Mode 6 draws layer 0 at 8 bpp. Each layer emits exactly TILES_X*TILES_Y*64 pixels.
- R3: A layer's map entries are read at consecutive byte pairs, tile by tile in row-major order. The first entry sits at the map base ((map register AND 0xFC) shifted left 9, truncated to the video RAM width). Within an entry, the tile index is {second byte bits 1:0, first byte} and the palette number is second byte bits 4:2.
- R4: Tile data starts at character base + tile index*8*bpp. The byte for row i and plane p sits at tile start + 2*i + 16*(p>>1) + (p&1).
- R5: Bit 7 of a plane byte is pixel column 0 of the row. Plane p supplies bit p of the colour index.
- R6: A zero colour index reads palette bytes 0 and 1. Any other index reads bytes 2*(palette*2^bpp + index) and the byte after it, modulo 512, low byte first. So at 8 bpp the palette number has no effect.
- R7: Pixel (column c, row r) of the layer is written at address r*TILES_X*8 + c.
- R8: Modes 4 and 7 emit no pixels and only pulse `frame_done_o`.
- R9: Only bits 2:0 of `mode_reg_i` select the mode.
- R10: While `pix_valid_o` is high and `pix_ready_i` is low, the pixel address and data hold and valid stays high.
- R11: `frame_done_o` is high for exactly one cycle per frame, after the last pixel of the frame has been accepted.
- R12: A start pulse during a frame is ignored; the running frame completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a frame |
| mode_reg_i | input | 8 | Mode register; bits 2:0 used |
| map_reg_i | input | 32 | Map base register per layer, layer n in bits 8n+7:8n |
| chr_base_i | input | 4*VRAM_AW | Character base byte address per layer, layer n at slice n |
| vram_addr_o | output | VRAM_AW | Video RAM byte read address |
| vram_rdata_i | input | 8 | Video RAM data, one cycle after address |
| pal_addr_o | output | PAL_AW | Palette RAM byte read address |
| pal_rdata_i | input | 8 | Palette RAM data, one cycle after address |
| pix_valid_o | output | 1 | Pixel write offered |
| pix_ready_i | input | 1 | Pixel write accepted |
| pix_addr_o | output | PIX_AW | Frame-buffer pixel index |
| pix_data_o | output | 16 | Pixel colour |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with TILES_X=3 and TILES_Y=2. This gives a 24-pixel row pitch that is not a power of two and keeps every mode's full frame within a few thousand cycles. Video RAM stays at the default 16-bit address width. A map register with its top bits set then lands its base near the top of memory, and tile starts at 8 bpp wrap around the address space. Video and palette contents are hash functions of the address, so random tile indices, palette numbers and zero colour indices all occur.

// File: rtl/tbr_pkg.sv
package tbr_pkg;
  localparam int NUM_LAYERS = 4;

  typedef enum logic [1:0] {
    BPP2 = 2'd0,
    BPP4 = 2'd1,
    BPP8 = 2'd2
  } bpp_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LAYER, S_MAP_LO, S_MAP_HI, S_MAP_END,
    S_PLN, S_PLN_END, S_PAL_LO, S_PAL_HI, S_PAL_END, S_OUT, S_DONE
  } state_e;

  // log2 of bits per pixel
  function automatic logic [1:0] bpp_log2(bpp_e b);
    case (b)
      BPP2:    return 2'd1;
      BPP4:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/tbr_sched.sv
module tbr_sched
  import tbr_pkg::*;
(
  input  logic [2:0] mode_i,
  input  logic [2:0] step_i,
  output logic [2:0] n_layers_o,
  output logic [1:0] layer_o,
  output bpp_e       bpp_o
);
  always_comb begin
    n_layers_o = 3'd0;
    layer_o    = 2'd0;
    bpp_o      = BPP2;
    case (mode_i)
      3'd0: begin
        n_layers_o = 3'd4;
        layer_o    = 2'(3'd3 - step_i);
        bpp_o      = BPP2;
      end
      3'd1: begin
        n_layers_o = 3'd3;
        layer_o    = 2'(3'd2 - step_i);
        bpp_o      = (step_i == 3'd0) ? BPP2 : BPP4;
      end
      3'd2: begin
        n_layers_o = 3'd2;
        layer_o    = 2'(3'd1 - step_i);
        bpp_o      = BPP4;
      end
      3'd3: begin
        n_layers_o = 3'd2;
        layer_o    = 2'(3'd1 - step_i);
        bpp_o      = (step_i == 3'd0) ? BPP4 : BPP8;
      end
      3'd5: begin
        n_layers_o = 3'd2;
        layer_o    = 2'(3'd1 - step_i);
        bpp_o      = (step_i == 3'd0) ? BPP2 : BPP4;
      end
      3'd6: begin
        n_layers_o = 3'd1;
        layer_o    = 2'd0;
        bpp_o      = BPP8;
      end
      default: n_layers_o = 3'd0;
    endcase
  end
endmodule

// File: rtl/tbr_planes.sv
module tbr_planes
  import tbr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [2:0] sel_i,
  input  logic [7:0] d_i,
  input  logic [2:0] col_i,
  input  bpp_e       bpp_i,
  output logic [7:0] cidx_o
);
  logic [7:0] pl_q [8];
  logic [3:0] n_planes;

  assign n_planes = 4'd1 << bpp_log2(bpp_i);

  for (genvar p = 0; p < 8; p++) begin : g_plane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          pl_q[p] <= 8'd0;
      else if (we_i && sel_i == 3'(p))      pl_q[p] <= d_i;
    end
    // bit 7 is the leftmost column
    assign cidx_o[p] = (4'(p) < n_planes) && pl_q[p][~col_i];
  end
endmodule

// File: rtl/tbr_engine.sv
module tbr_engine
  import tbr_pkg::*;
#(
  parameter int TILES_X = 32,
  parameter int TILES_Y = 28,
  parameter int VRAM_AW = 16,
  parameter int PAL_AW  = 9,
  parameter int PIX_AW  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [7:0]                mode_reg_i,
  input  logic [8*NUM_LAYERS-1:0]   map_reg_i,
  input  logic [VRAM_AW*NUM_LAYERS-1:0] chr_base_i,
  output logic [2:0]                mode_o,
  output logic [2:0]                step_o,
  input  logic [2:0]                n_layers_i,
  input  logic [1:0]                layer_i,
  input  bpp_e                      bpp_i,
  output logic                      pl_we_o,
  output logic [2:0]                pl_sel_o,
  output logic [7:0]                pl_d_o,
  output logic [2:0]                col_o,
  input  logic [7:0]                cidx_i,
  output logic [VRAM_AW-1:0]        vram_addr_o,
  input  logic [7:0]                vram_rdata_i,
  output logic [PAL_AW-1:0]         pal_addr_o,
  input  logic [7:0]                pal_rdata_i,
  output logic                      pix_valid_o,
  input  logic                      pix_ready_i,
  output logic [PIX_AW-1:0]         pix_addr_o,
  output logic [15:0]               pix_data_o,
  output logic                      frame_done_o
);
  localparam int XW      = (TILES_X > 1) ? $clog2(TILES_X) : 1;
  localparam int YW      = (TILES_Y > 1) ? $clog2(TILES_Y) : 1;
  localparam int ROW_PIX = TILES_X * 8;

  state_e             state_q;
  logic [2:0]         mode_q, step_q, i_q, j_q, pl_q;
  logic [XW-1:0]      x_q;
  logic [YW-1:0]      y_q;
  logic [VRAM_AW-1:0] map_ptr_q;
  logic [7:0]         ent_lo_q, ent_hi_q, col_lo_q;
  logic [15:0]        pix_q;

  logic [1:0]         sh;
  logic [3:0]         n_planes;
  logic [16:0]        map_full;
  logic [VRAM_AW-1:0] map_base, chr_base, tile_start, plane_addr;
  logic [31:0]        ts_off, pal_full, pix_full;
  logic [PAL_AW-1:0]  pal_base;
  logic               last_pl, last_x, last_y;

  assign sh        = bpp_log2(bpp_i);
  assign n_planes  = 4'd1 << sh;
  assign map_full  = {map_reg_i[8*layer_i +: 8] & 8'hFC, 9'd0};
  assign map_base  = VRAM_AW'(map_full);
  assign chr_base  = chr_base_i[VRAM_AW*layer_i +: VRAM_AW];
  assign ts_off    = 32'({ent_hi_q[1:0], ent_lo_q}) << (32'(sh) + 32'd3);
  assign tile_start = chr_base + VRAM_AW'(ts_off);
  assign plane_addr = tile_start + VRAM_AW'({i_q, 1'b0}) + VRAM_AW'({pl_q[2:1], 4'd0})
                    + VRAM_AW'(pl_q[0]);
  assign pal_full  = ((32'(ent_hi_q[4:2]) << n_planes) + 32'(cidx_i)) << 1;
  assign pal_base  = (cidx_i == 8'd0) ? '0 : PAL_AW'(pal_full);
  assign pix_full  = (32'(y_q) * 8 + 32'(i_q)) * ROW_PIX + 32'(x_q) * 8 + 32'(j_q);
  assign last_pl   = (4'(pl_q) == n_planes - 4'd1);
  assign last_x    = (x_q == XW'(TILES_X - 1));
  assign last_y    = (y_q == YW'(TILES_Y - 1));

  always_comb begin
    vram_addr_o = '0;
    pal_addr_o  = '0;
    pl_we_o     = 1'b0;
    pl_sel_o    = pl_q - 3'd1;
    case (state_q)
      S_MAP_LO:  vram_addr_o = map_ptr_q;
      S_MAP_HI:  vram_addr_o = map_ptr_q + VRAM_AW'(1);
      S_PLN: begin
        vram_addr_o = plane_addr;
        pl_we_o     = (pl_q != 3'd0);
      end
      S_PLN_END: begin
        pl_we_o  = 1'b1;
        pl_sel_o = pl_q;
      end
      S_PAL_LO:  pal_addr_o = pal_base;
      S_PAL_HI:  pal_addr_o = pal_base + PAL_AW'(1);
      default: ;
    endcase
  end

  assign pl_d_o       = vram_rdata_i;
  assign col_o        = j_q;
  assign mode_o       = mode_q;
  assign step_o       = step_q;
  assign pix_valid_o  = (state_q == S_OUT);
  assign pix_addr_o   = PIX_AW'(pix_full);
  assign pix_data_o   = pix_q;
  assign frame_done_o = (state_q == S_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      mode_q    <= '0;
      step_q    <= '0;
      i_q       <= '0;
      j_q       <= '0;
      pl_q      <= '0;
      x_q       <= '0;
      y_q       <= '0;
      map_ptr_q <= '0;
      ent_lo_q  <= '0;
      ent_hi_q  <= '0;
      col_lo_q  <= '0;
      pix_q     <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start_i) begin
          mode_q  <= mode_reg_i[2:0];
          step_q  <= '0;
          state_q <= S_LAYER;
        end
        S_LAYER: if (step_q >= n_layers_i) state_q <= S_DONE;
        else begin
          map_ptr_q <= map_base;
          x_q       <= '0;
          y_q       <= '0;
          state_q   <= S_MAP_LO;
        end
        S_MAP_LO:  state_q <= S_MAP_HI;
        S_MAP_HI: begin
          ent_lo_q <= vram_rdata_i;
          state_q  <= S_MAP_END;
        end
        S_MAP_END: begin
          ent_hi_q <= vram_rdata_i;
          i_q      <= '0;
          pl_q     <= '0;
          state_q  <= S_PLN;
        end
        S_PLN: if (last_pl) state_q <= S_PLN_END;
               else pl_q <= pl_q + 3'd1;
        S_PLN_END: begin
          j_q     <= '0;
          state_q <= S_PAL_LO;
        end
        S_PAL_LO:  state_q <= S_PAL_HI;
        S_PAL_HI: begin
          col_lo_q <= pal_rdata_i;
          state_q  <= S_PAL_END;
        end
        S_PAL_END: begin
          pix_q   <= {pal_rdata_i, col_lo_q};
          state_q <= S_OUT;
        end
        S_OUT: if (pix_ready_i) begin
          if (j_q != 3'd7) begin
            j_q     <= j_q + 3'd1;
            state_q <= S_PAL_LO;
          end else if (i_q != 3'd7) begin
            i_q     <= i_q + 3'd1;
            pl_q    <= '0;
            state_q <= S_PLN;
          end else begin
            map_ptr_q <= map_ptr_q + VRAM_AW'(2);
            if (!last_x) begin
              x_q     <= x_q + XW'(1);
              state_q <= S_MAP_LO;
            end else if (!last_y) begin
              x_q     <= '0;
              y_q     <= y_q + YW'(1);
              state_q <= S_MAP_LO;
            end else begin
              step_q  <= step_q + 3'd1;
              state_q <= S_LAYER;
            end
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o && !pix_ready_i |=> pix_valid_o && $stable(pix_addr_o) && $stable(pix_data_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);
  // R8
  blank_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (mode_q != 3'd4) && (mode_q != 3'd7));
  // R2
  bpp_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |-> (bpp_i != 2'd3) && (step_q < n_layers_i));
  // R12
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_IDLE) && (state_q != S_DONE) && start_i |=> state_q != S_IDLE);
endmodule

// File: rtl/tile_bg_render.sv
module tile_bg_render
  import tbr_pkg::*;
#(
  parameter int TILES_X = 32,
  parameter int TILES_Y = 28,
  parameter int VRAM_AW = 16,
  parameter int PAL_AW  = 9,
  localparam int PIX_AW = $clog2(TILES_X * TILES_Y * 64)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          start_i,
  input  logic [7:0]                    mode_reg_i,
  input  logic [8*NUM_LAYERS-1:0]       map_reg_i,
  input  logic [VRAM_AW*NUM_LAYERS-1:0] chr_base_i,
  output logic [VRAM_AW-1:0]            vram_addr_o,
  input  logic [7:0]                    vram_rdata_i,
  output logic [PAL_AW-1:0]             pal_addr_o,
  input  logic [7:0]                    pal_rdata_i,
  output logic                          pix_valid_o,
  input  logic                          pix_ready_i,
  output logic [PIX_AW-1:0]             pix_addr_o,
  output logic [15:0]                   pix_data_o,
  output logic                          frame_done_o
);
  logic [2:0] mode, step, n_layers, col;
  logic [1:0] layer;
  bpp_e       bpp;
  logic       pl_we;
  logic [2:0] pl_sel;
  logic [7:0] pl_d, cidx;

  tbr_sched u_sched (
    .mode_i     (mode),
    .step_i     (step),
    .n_layers_o (n_layers),
    .layer_o    (layer),
    .bpp_o      (bpp)
  );

  tbr_planes u_planes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (pl_we),
    .sel_i  (pl_sel),
    .d_i    (pl_d),
    .col_i  (col),
    .bpp_i  (bpp),
    .cidx_o (cidx)
  );

  tbr_engine #(
    .TILES_X (TILES_X),
    .TILES_Y (TILES_Y),
    .VRAM_AW (VRAM_AW),
    .PAL_AW  (PAL_AW),
    .PIX_AW  (PIX_AW)
  ) u_engine (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .mode_reg_i   (mode_reg_i),
    .map_reg_i    (map_reg_i),
    .chr_base_i   (chr_base_i),
    .mode_o       (mode),
    .step_o       (step),
    .n_layers_i   (n_layers),
    .layer_i      (layer),
    .bpp_i        (bpp),
    .pl_we_o      (pl_we),
    .pl_sel_o     (pl_sel),
    .pl_d_o       (pl_d),
    .col_o        (col),
    .cidx_i       (cidx),
    .vram_addr_o  (vram_addr_o),
    .vram_rdata_i (vram_rdata_i),
    .pal_addr_o   (pal_addr_o),
    .pal_rdata_i  (pal_rdata_i),
    .pix_valid_o  (pix_valid_o),
    .pix_ready_i  (pix_ready_i),
    .pix_addr_o   (pix_addr_o),
    .pix_data_o   (pix_data_o),
    .frame_done_o (frame_done_o)
  );
endmodule

// File: tb/sim_tile_bg_render.sv
module sim_tile_bg_render;
  localparam int TX     = 3;
  localparam int TY     = 2;
  localparam int VAW    = 16;
  localparam int PAW    = 9;
  localparam int PIXW   = $clog2(TX * TY * 64);
  localparam int LPIX   = TX * TY * 64;
  localparam int WD     = 60000;

  typedef struct packed {
    logic [7:0] mreg;
    logic [2:0] layers;
    logic       stall;
    logic       mid;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'h00, 3'd4, 1'b0, 1'b0},
    '{8'h01, 3'd3, 1'b1, 1'b0},
    '{8'h02, 3'd2, 1'b0, 1'b1},
    '{8'h03, 3'd2, 1'b1, 1'b0},
    '{8'h04, 3'd0, 1'b0, 1'b0},
    '{8'h05, 3'd2, 1'b0, 1'b0},
    '{8'h06, 3'd1, 1'b1, 1'b0},
    '{8'h07, 3'd0, 1'b0, 1'b0},
    '{8'hF9, 3'd3, 1'b0, 1'b0},
    '{8'h0E, 3'd1, 1'b1, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [7:0]        mode_reg = 8'd0;
  logic [31:0]       map_reg = {8'hFE, 8'h0B, 8'h06, 8'h03};
  logic [4*VAW-1:0]  chr_base = {16'h8000, 16'h6000, 16'h4000, 16'h2000};
  logic [VAW-1:0]    vram_addr;
  logic [7:0]        vram_rdata = 8'd0;
  logic [PAW-1:0]    pal_addr;
  logic [7:0]        pal_rdata = 8'd0;
  logic              pix_valid, pix_ready = 1'b1, frame_done;
  logic [PIXW-1:0]   pix_addr;
  logic [15:0]       pix_data;
  int                total = 0, bad = 0;

  always #10 clk = ~clk;

  tile_bg_render #(.TILES_X(TX), .TILES_Y(TY), .VRAM_AW(VAW), .PAL_AW(PAW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_reg_i(mode_reg),
    .map_reg_i(map_reg), .chr_base_i(chr_base),
    .vram_addr_o(vram_addr), .vram_rdata_i(vram_rdata),
    .pal_addr_o(pal_addr), .pal_rdata_i(pal_rdata),
    .pix_valid_o(pix_valid), .pix_ready_i(pix_ready),
    .pix_addr_o(pix_addr), .pix_data_o(pix_data), .frame_done_o(frame_done)
  );

  function automatic logic [7:0] vb(input int a);
    logic [15:0] w;
    w = 16'(a);
    return (w[7:0] * 8'd29) ^ w[15:8] ^ (w[7:0] >> 3) ^ 8'h3C;
  endfunction

  function automatic logic [7:0] pb(input int a);
    logic [8:0] w;
    w = 9'(a);
    return (w[7:0] * 8'd13) ^ {w[8], 7'd0} ^ 8'h5A;
  endfunction

  // synchronous RAM models, one cycle latency
  always @(posedge clk) begin
    vram_rdata <= vb(int'(vram_addr));
    pal_rdata  <= pb(int'(pal_addr));
  end

  // layer schedule per R2
  function automatic void bsched(input int mode, input int k, output int lay, output int bpp);
    lay = 0; bpp = 2;
    case (mode)
      0: begin lay = 3 - k; bpp = 2; end
      1: begin lay = 2 - k; bpp = (k == 0) ? 2 : 4; end
      2: begin lay = 1 - k; bpp = 4; end
      3: begin lay = 1 - k; bpp = (k == 0) ? 4 : 8; end
      5: begin lay = 1 - k; bpp = (k == 0) ? 2 : 4; end
      6: begin lay = 0; bpp = 8; end
      default: ;
    endcase
  endfunction

  // expected pixel n of a layer per R3..R7
  function automatic void model(input int lay, input int bpp, input int n,
                                output int ea, output logic [15:0] ed);
    int t, x, y, i, j, mb, ent, lo, hi, idx, pal, ts, c, pa;
    t  = n / 64; x = t % TX; y = t / TX; i = (n / 8) % 8; j = n % 8;
    mb = ((int'(map_reg[8*lay +: 8]) & 'hFC) << 9) & 'hFFFF;
    ent = (mb + 2 * t) & 'hFFFF;
    lo = int'(vb(ent)); hi = int'(vb(ent + 1));
    idx = ((hi & 3) << 8) | lo;
    pal = (hi >> 2) & 7;
    ts = (int'(chr_base[16*lay +: 16]) + idx * 8 * bpp) & 'hFFFF;
    c = 0;
    for (int p = 0; p < bpp; p++) begin
      logic [7:0] b;
      b = vb((ts + 2 * i + 16 * (p / 2) + (p % 2)) & 'hFFFF);
      c = c | (int'(b[7 - j]) << p);
    end
    pa = (c == 0) ? 0 : (((pal * (1 << bpp) + c) * 2) % 512);
    ed = {pb(pa + 1), pb(pa)};
    ea = (y * 8 + i) * TX * 8 + x * 8 + j;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input vec_t v);
    int g = 0, cyc = 0, dones = 0, lay, bpp, ea, mode;
    bit held = 0;
    logic [PIXW-1:0] h_addr;
    logic [15:0] h_data, ed;
    mode = int'(v.mreg[2:0]);
    @(negedge clk);
    mode_reg = v.mreg;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (dones == 0 && cyc < WD) begin
      @(negedge clk);
      cyc++;
      pix_ready = v.stall ? (cyc % 3 != 1) : 1'b1;
      start = v.mid && (cyc == 50);         // R12 stray start mid-frame
      if (v.mid && cyc == 50) mode_reg = 8'h00;
      if (held)  // R10
        chk(pix_valid && pix_addr == h_addr && pix_data == h_data, "R10",
            int'(pix_data), int'(h_data));
      if (frame_done) dones++;
      if (pix_valid && pix_ready) begin
        if (g >= int'(v.layers) * LPIX) chk(1'b0, "R2 extra pixel", g, int'(v.layers) * LPIX);
        else begin
          bsched(mode, g / LPIX, lay, bpp);
          model(lay, bpp, g % LPIX, ea, ed);
          // R3 R4 R5 R6 R7
          chk(int'(pix_addr) == ea, "R7 pixel address", int'(pix_addr), ea);
          chk(pix_data == ed, "R6 pixel colour", int'(pix_data), int'(ed));
        end
        g++;
      end
      held = pix_valid && !pix_ready;
      h_addr = pix_addr; h_data = pix_data;
    end
    start = 1'b0;
    pix_ready = 1'b1;
    chk(dones == 1, "R11 watchdog / frame done", dones, 1);
    // R2 R8 R9 R12 pixel count per mode
    chk(g == int'(v.layers) * LPIX, "R2 pixel count", g, int'(v.layers) * LPIX);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!frame_done && !pix_valid, "R11 quiet after done", int'(frame_done), 0);
    end
  endtask

  initial begin
    #35;
    chk(!pix_valid && !frame_done, "R1 in reset", int'(pix_valid), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(!pix_valid && !frame_done, "R1 idle", int'(frame_done), 0);
    end
    for (int n = 0; n < 10; n++) run_frame(VECS[n]);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule